// File: doc/BRIEF.md
# Nested Strong-Priority Interrupt Arbiter

This block decides, on behalf of a simple processor, when an interrupt is taken and which device is served. Each interrupt source has its own priority level, held in a small table that is loaded through a configuration port. The processor's current execution level is kept here as a 3-bit field. Level 0 means ordinary program code runs.

When the processor signals an interruptible instruction boundary, the block finds the highest level among the devices now requesting. It takes that request only when its level is strictly above the current level. On a take it pulses a strobe and reports the device index. It also pushes the interrupted level onto a nesting stack and raises the current level to the winner's level. A handler return pops the stack and restores the earlier level. This gives preemption by higher levels only, and a handler is never re-entered from its own level. Devices on the same level are ordered by a fixed chain, and the lowest index wins.

Requests are level-sensitive and are not latched. A request stays pending until software clears the device's line. A global enable input, when low, defers every request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cur_pri` is 0, `take_irq` is 0, `irq_id` is 0, and every device's level is 0.
- R2: A write with `cfg_we` high stores `cfg_lvl` as the level of device `cfg_idx`. A device at level 0 can never interrupt, because no current level is below 0.
- R3: An interrupt is decided only on a cycle with `instr_bnd` high. `take_irq` is a one-cycle pulse in the cycle after that boundary, and it is never raised without a boundary.
- R4: At a boundary, let L be the highest level among the requesting devices. If L > `cur_pri`, the next cycle shows `take_irq`=1, `irq_id` set to the winning device, and `cur_pri`=L. A higher level wins over a lower device index.
- R5: A request whose level is equal to or below `cur_pri` is deferred, and `cur_pri` does not change. The request stays pending, so it is taken at a later boundary once the level has dropped.
- R6: Among requesting devices that share the highest level, the lowest device index wins.
- R7: While `glob_en` is 0, no request is taken at a boundary.
- R8: A cycle with `rti` high pops the nesting stack and restores the level that was current before the most recent take. Nested takes unwind in last-in, first-out order.
- R9: An `rti` while the stack is empty is ignored, and `cur_pri` stays 0.
- R10: When `rti` and `instr_bnd` are high in the same cycle, the return is performed and no interrupt is taken in that cycle.
- R11: Requests are not latched. A request that is withdrawn before a boundary is not taken at that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Global interrupt enable; low defers all requests |
| req | input | N_SRC | Level-sensitive request line per device |
| cfg_we | input | 1 | Level table write strobe |
| cfg_idx | input | IDX_W | Device whose level is written |
| cfg_lvl | input | LVL_W | Level value to write |
| instr_bnd | input | 1 | Interruptible instruction boundary strobe |
| rti | input | 1 | Handler return strobe |
| take_irq | output | 1 | One-cycle pulse when an interrupt is taken |
| irq_id | output | IDX_W | Index of the device being served |
| cur_pri | output | LVL_W | Current processor priority level |

## Verification
The bench checks that an equal-level request is held off while its handler runs. A design that compares with >= instead of > would re-enter the handler. It also checks that a higher-level device beats a lower index, and that ties on one level go to the lowest index. A reversed chain, or an arbiter that only looks at index, would report the wrong device. Nested takes are unwound one return at a time, and an extra return on an empty stack must leave level 0. A stack that underflows would restore a stale level. Further cases cover a return that coincides with a boundary, a disabled period, a request dropped before a boundary, and a device left at level 0. Each of these catches a controller that takes when it should defer.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Strict comparison: a request preempts only a strictly lower running level.
  function automatic logic level_preempts(input logic [2:0] req_lvl, input logic [2:0] run_lvl);
    return req_lvl > run_lvl;
  endfunction

  // Chain order: candidate replaces current best when its level is at least as high,
  // scanning from the highest index down so the lowest index wins ties.
  function automatic logic chain_replaces(input logic [2:0] cand_lvl, input logic [2:0] best_lvl,
                                          input logic best_vld);
    return !best_vld || (cand_lvl >= best_lvl);
  endfunction
endpackage

// File: rtl/pic_lvl_table.sv
module pic_lvl_table #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [LVL_W-1:0]             cfg_lvl,
  output logic [N_SRC-1:0][LVL_W-1:0]  lvl_tab
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_tab[g] <= '0;
      else if (cfg_we && (cfg_idx == IDX_W'(g))) lvl_tab[g] <= cfg_lvl;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             req,
  input  logic [N_SRC-1:0][LVL_W-1:0]  lvl_tab,
  output logic                         win_vld,
  output logic [IDX_W-1:0]             win_id,
  output logic [LVL_W-1:0]             win_lvl
);
  import pic_pkg::*;
  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i] && chain_replaces(lvl_tab[i], win_lvl, win_vld)) begin
        win_vld = 1'b1;
        win_id  = IDX_W'(i);
        win_lvl = lvl_tab[i];
      end
    end
  end
endmodule

// File: rtl/pic_pri_stack.sv
module pic_pri_stack #(
  parameter int LVL_W = 3,
  parameter int STK_DEPTH = 8,
  localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ev,
  input  logic [LVL_W-1:0] new_lvl,
  input  logic             pop_req,
  output logic             pop_ev,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [CNT_W-1:0] stk_cnt
);
  logic [LVL_W-1:0] stk_mem [STK_DEPTH];
  logic             can_push;

  assign pop_ev   = pop_req && (stk_cnt != '0);
  assign can_push = push_ev && (stk_cnt < CNT_W'(STK_DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= '0;
      stk_cnt <= '0;
    end else if (pop_ev) begin
      cur_lvl <= stk_mem[stk_cnt - 1'b1];
      stk_cnt <= stk_cnt - 1'b1;
    end else if (can_push) begin
      cur_lvl <= new_lvl;
      stk_cnt <= stk_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (can_push && !pop_ev) stk_mem[stk_cnt[$clog2(STK_DEPTH)-1:0]] <= cur_lvl;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  parameter int STK_DEPTH = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_en,
  input  logic [N_SRC-1:0] req,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic             instr_bnd,
  input  logic             rti,
  output logic             take_irq,
  output logic [IDX_W-1:0] irq_id,
  output logic [LVL_W-1:0] cur_pri
);
  import pic_pkg::*;

  logic [N_SRC-1:0][LVL_W-1:0] lvl_tab;
  logic             arb_vld;
  logic [IDX_W-1:0] arb_id;
  logic [LVL_W-1:0] arb_lvl;
  logic             take_ev;
  logic             pop_ev;
  logic [CNT_W-1:0] stk_cnt;

  pic_lvl_table #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lvl(cfg_lvl), .lvl_tab(lvl_tab)
  );

  pic_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .req(req), .lvl_tab(lvl_tab), .win_vld(arb_vld), .win_id(arb_id), .win_lvl(arb_lvl)
  );

  // Take only at a boundary, when enabled, not during a return, and strictly above.
  assign take_ev = instr_bnd && glob_en && !rti && arb_vld && level_preempts(arb_lvl, cur_pri);

  pic_pri_stack #(.LVL_W(LVL_W), .STK_DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_ev(take_ev), .new_lvl(arb_lvl),
    .pop_req(rti), .pop_ev(pop_ev), .cur_lvl(cur_pri), .stk_cnt(stk_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_irq <= 1'b0;
      irq_id   <= '0;
    end else begin
      take_irq <= take_ev;
      if (take_ev) irq_id <= arb_id;
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int LVL_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glob_en,
  input logic             instr_bnd,
  input logic             rti,
  input logic             take_irq,
  input logic [LVL_W-1:0] cur_pri,
  input logic [CNT_W-1:0] stk_cnt,
  input logic             pop_ev
);
  AST_TAKE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (cur_pri > $past(cur_pri))); // R4
  AST_NO_TAKE_OFF_BND: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_bnd |=> !take_irq); // R3
  AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !take_irq); // R7
  AST_NO_TAKE_ON_RTI: assert property (@(posedge clk) disable iff (!rst_n)
    rti |=> !take_irq); // R10
  AST_PRI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_bnd && !rti) |=> $stable(cur_pri)); // R5
  AST_EMPTY_RTI: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && stk_cnt == '0) |=> (cur_pri == '0)); // R9
  AST_POP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> (cur_pri < $past(cur_pri))); // R8
endmodule

bind prio_irq_ctrl pic_checker #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .instr_bnd(instr_bnd), .rti(rti),
  .take_irq(take_irq), .cur_pri(cur_pri), .stk_cnt(stk_cnt), .pop_ev(pop_ev)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glob_en = 1'b1;
  logic [N-1:0] req = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [2:0] cfg_lvl = '0;
  logic instr_bnd = 1'b0;
  logic rti = 1'b0;
  logic take_irq;
  logic [2:0] irq_id;
  logic [2:0] cur_pri;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .req(req), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .instr_bnd(instr_bnd), .rti(rti),
    .take_irq(take_irq), .irq_id(irq_id), .cur_pri(cur_pri)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic set_lvl(input int dev, input int lvl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(dev); cfg_lvl = 3'(lvl);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One boundary cycle; outputs sampled on the following falling edge.
  task automatic boundary();
    @(negedge clk);
    instr_bnd = 1'b1;
    @(negedge clk);
    instr_bnd = 1'b0;
  endtask

  task automatic do_rti();
    @(negedge clk);
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cur_pri", int'(cur_pri), 0);
    chk("R1 take_irq", int'(take_irq), 0);
    chk("R1 irq_id", int'(irq_id), 0);
    req = 8'h08;               // device 3 still at reset level 0
    boundary();
    chk("R1 reset level blocks take", int'(take_irq), 0);
    req = '0;
  endtask

  task automatic t_take_and_defer();
    set_lvl(2, 3);
    set_lvl(5, 3);
    req[2] = 1'b1;
    @(negedge clk);
    chk("R3 no take without boundary", int'(take_irq), 0);
    boundary();
    chk("R4 take", int'(take_irq), 1);
    chk("R4 id", int'(irq_id), 2);
    chk("R4 pri", int'(cur_pri), 3);
    @(negedge clk);
    chk("R3 pulse one cycle", int'(take_irq), 0);
    req[5] = 1'b1;
    boundary();
    chk("R5 same level deferred", int'(take_irq), 0);
    chk("R5 pri kept", int'(cur_pri), 3);
  endtask

  task automatic t_nesting();
    set_lvl(6, 6);
    req[6] = 1'b1;
    boundary();
    chk("R8 nested take", int'(take_irq), 1);
    chk("R8 nested id", int'(irq_id), 6);
    chk("R8 nested pri", int'(cur_pri), 6);
    req[6] = 1'b0;
    do_rti();
    chk("R8 pop to 3", int'(cur_pri), 3);
    req[2] = 1'b0;
    do_rti();
    chk("R8 pop to 0", int'(cur_pri), 0);
    do_rti();
    chk("R9 empty rti", int'(cur_pri), 0);
    boundary();
    chk("R5 pending taken later", int'(take_irq), 1);
    chk("R5 pending id", int'(irq_id), 5);
    req[5] = 1'b0;
    do_rti();
  endtask

  task automatic t_ties();
    set_lvl(1, 4);
    set_lvl(4, 4);
    req = 8'h12;
    boundary();
    chk("R6 tie id", int'(irq_id), 1);
    chk("R6 tie pri", int'(cur_pri), 4);
    req = '0;
    do_rti();
    set_lvl(7, 7);
    req = 8'h82;
    boundary();
    chk("R4 higher level beats index", int'(irq_id), 7);
    chk("R4 level 7", int'(cur_pri), 7);
    req = '0;
    do_rti();
    chk("R8 back to 0", int'(cur_pri), 0);
  endtask

  task automatic t_level0();
    req = 8'h01;               // device 0 at level 0
    boundary();
    chk("R2 level0 never taken", int'(take_irq), 0);
    req = '0;
  endtask

  task automatic t_disable();
    glob_en = 1'b0;
    req = 8'h10;
    boundary();
    chk("R7 disabled defer", int'(take_irq), 0);
    chk("R7 pri kept", int'(cur_pri), 0);
    glob_en = 1'b1;
    boundary();
    chk("R7 enabled take id", int'(irq_id), 4);
    chk("R7 enabled pri", int'(cur_pri), 4);
  endtask

  task automatic t_rti_and_bnd();
    req = 8'h40;               // device 6 level 6 while at 4
    req[4] = 1'b0;
    @(negedge clk);
    instr_bnd = 1'b1; rti = 1'b1;
    @(negedge clk);
    instr_bnd = 1'b0; rti = 1'b0;
    chk("R10 no take with rti", int'(take_irq), 0);
    chk("R10 rti done", int'(cur_pri), 0);
    boundary();
    chk("R10 take next boundary", int'(irq_id), 6);
    chk("R10 pri 6", int'(cur_pri), 6);
    req = '0;
    do_rti();
  endtask

  task automatic t_unlatched();
    @(negedge clk);
    req = 8'h80;
    @(negedge clk);
    req = '0;
    boundary();
    chk("R11 dropped req not taken", int'(take_irq), 0);
    chk("R11 pri 0", int'(cur_pri), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_take_and_defer();
    t_nesting();
    t_ties();
    t_level0();
    t_disable();
    t_rti_and_bnd();
    t_unlatched();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule